// File: doc/BRIEF.md
# Indirect Operand Address Generator

This block turns a decoded indirect-mode operand into one or two memory accesses for a small 16-bit CPU that keeps its registers in a byte-indexed register file. The operand field names a word-aligned pointer register. Bit 0 of that field is free because of the alignment, and it selects post-access autoincrement. The step is 1 for a byte operand and 2 for a word operand. A normal pointer is one 16-bit register. An extended pointer is 24 bits wide and spans two registers: the low half sits at the named index and bits 23:16 sit in the low byte of the register two bytes above it. Only its low 20 bits drive the memory address, which gives a 1-Mbyte reach.

The block also owns the stack pointer. A push moves a word from the pointed-to location onto the stack. A pop moves a word from the stack to the pointed-to location. Each of these takes two memory accesses. Loads write the fetched data into a destination register. Stores send the contents of a source register. Pointer updates are written back through the register-file write port once the last access has been acknowledged. The block is busy for the whole sequence and ignores any command offered meanwhile.

Top module: `ptr_agu`

## Requirements
- R1: Command kind encoding: `cmd_kind` is 0 for normal, 1 for extended, 2 for push and 3 for pop. `cmd_word`=1 means word and 0 means byte. `cmd_load`=1 means load and 0 means store, for kinds 0 and 1. A normal access uses the 16-bit contents of the pointer register, zero-extended, as `mem_addr`. A byte load writes the fetched byte zero-extended into register `cmd_dreg`. A word load writes the whole word. A store sends the full contents of register `cmd_dreg` on `mem_wdata`.
- R2: The pointer register index is `cmd_field` with bit 0 cleared. When `cmd_field` bit 0 is 1, the pointer grows by 1 (byte) or 2 (word) after the access. When bit 0 is 0, the pointer register is never written.
- R3: An extended pointer is {low byte of register index+2, register index}. `mem_addr` is its bits 19:0. It wraps modulo 2^24 and is written back as low word plus high byte, with the high register's upper byte cleared. Normal pointers wrap modulo 2^16.
- R4: A push lowers the stack pointer by 2, reads the word at the pointer, writes it at the new stack pointer, and then adds 2 to the pointer if autoincrement is selected.
- R5: A pop reads the word at the stack pointer, raises the stack pointer by 2, writes the word at the pointer, and then adds 2 to the pointer if autoincrement is selected.
- R6: `mem_addr`, `mem_we` and `mem_word` stay stable while `mem_req` is high without `mem_ack`. The pointer writeback of the low word occurs in the cycle after the final acknowledge. No register write overlaps an open request.
- R7: If a load's destination register is the autoincremented pointer register, the register ends with the loaded data and the increment is discarded.
- R8: `busy` rises in the cycle after a command is accepted and falls once writeback completes. `cmd_valid` while busy has no effect.
- R9: Synchronous reset clears the stack pointer to 0, drops `mem_req` and `busy`, and issues no register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered (taken only when idle) |
| cmd_field | input | 8 | Pointer register field, bit 0 = autoincrement |
| cmd_dreg | input | 8 | Data register index (load destination or store source) |
| cmd_word | input | 1 | 1 = word operand, 0 = byte |
| cmd_load | input | 1 | 1 = load, 0 = store (normal and extended kinds) |
| cmd_kind | input | 2 | 0 normal, 1 extended, 2 push, 3 pop |
| busy | output | 1 | Operation in progress |
| rf_ra_addr | output | 8 | Register-file read port A index |
| rf_ra_data | input | 16 | Read port A data (combinational) |
| rf_rb_addr | output | 8 | Register-file read port B index |
| rf_rb_data | input | 16 | Read port B data (combinational) |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 8 | Register-file write index |
| rf_wdata | output | 16 | Register-file write data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write access |
| mem_word | output | 1 | 1 = word access, 0 = byte |
| mem_addr | output | 20 | Byte address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with acknowledge |
| mem_ack | input | 1 | Completes the current request |
| sp_value | output | 16 | Current stack pointer |

## Verification
The assertions assume a memory that raises `mem_ack` only while `mem_req` is high, for one cycle per access. They also assume that nothing but this block writes the register file during an operation, since store data is read live from the source register while the request is held. The bench memory model follows both rules: it acknowledges after a per-operation latency of 0 to 3 cycles and drops the acknowledge on the next cycle. Register and memory contents are preset only while the block is idle. The stack pointer is only ever moved in steps of 2, and the bench checks that reach directly rather than through any unconstrained input.

// File: rtl/ptr_agu_pkg.sv
package ptr_agu_pkg;

    localparam int REG_IDX_W  = 8;
    localparam int DATA_W     = 16;
    localparam int EXT_W      = 24;
    localparam int MADDR_W    = 20;
    localparam int BYTE_W     = 8;
    localparam int HI_W       = EXT_W - DATA_W;
    localparam int WORD_BYTES = DATA_W / BYTE_W;

    typedef enum logic [1:0] {
        KIND_PLAIN = 2'd0,
        KIND_EXT   = 2'd1,
        KIND_PUSH  = 2'd2,
        KIND_POP   = 2'd3
    } acc_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GRAB,
        ST_MEM1,
        ST_MEM2,
        ST_WB_LO,
        ST_WB_HI,
        ST_WB_DATA
    } agu_state_e;

    typedef struct packed {
        logic [REG_IDX_W-1:0] preg;
        logic                 autoinc;
        logic [REG_IDX_W-1:0] dreg;
        logic                 word;
        logic                 load;
        acc_kind_e            kind;
    } agu_cmd_t;

    function automatic agu_cmd_t decode_cmd(
        input logic [REG_IDX_W-1:0] field,
        input logic [REG_IDX_W-1:0] dreg,
        input logic                 word,
        input logic                 load,
        input logic [1:0]           kind
    );
        agu_cmd_t c;
        c.preg    = {field[REG_IDX_W-1:1], 1'b0};
        c.autoinc = field[0];
        c.dreg    = dreg;
        c.word    = word;
        c.load    = load;
        c.kind    = acc_kind_e'(kind);
        return c;
    endfunction

    function automatic logic is_stack(input acc_kind_e k);
        return (k == KIND_PUSH) || (k == KIND_POP);
    endfunction

endpackage

// File: rtl/ptr_agu_ctrl.sv
module ptr_agu_ctrl
    import ptr_agu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  agu_cmd_t   cmd_in,
    input  logic       mem_ack,
    output agu_state_e state,
    output agu_cmd_t   cmd_q
);

    agu_state_e state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (cmd_valid) state_nx = ST_GRAB;
            ST_GRAB:    state_nx = ST_MEM1;
            ST_MEM1:    if (mem_ack) state_nx = is_stack(cmd_q.kind) ? ST_MEM2 : ST_WB_LO;
            ST_MEM2:    if (mem_ack) state_nx = ST_WB_LO;
            ST_WB_LO: begin
                if (cmd_q.kind == KIND_EXT)                     state_nx = ST_WB_HI;
                else if (cmd_q.kind == KIND_PLAIN && cmd_q.load) state_nx = ST_WB_DATA;
                else                                             state_nx = ST_IDLE;
            end
            ST_WB_HI:   state_nx = cmd_q.load ? ST_WB_DATA : ST_IDLE;
            ST_WB_DATA: state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cmd_q <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && cmd_valid) begin
                cmd_q <= cmd_in;
            end
        end
    end

endmodule

// File: rtl/ptr_agu_sp.sv
module ptr_agu_sp #(
    parameter int W    = 16,
    parameter int STEP = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         dec,
    input  logic         inc,
    output logic [W-1:0] sp
);

    always_ff @(posedge clk) begin
        if (rst) begin
            sp <= '0;
        end else if (dec) begin
            sp <= sp - W'(STEP);
        end else if (inc) begin
            sp <= sp + W'(STEP);
        end
    end

endmodule

// File: rtl/ptr_agu_step.sv
module ptr_agu_step #(
    parameter int DW = 16,
    parameter int EW = 24
) (
    input  logic [EW-1:0] ptr_in,
    input  logic          ext,
    input  logic          word,
    output logic [EW-1:0] ptr_next
);

    localparam int HW = EW - DW;

    logic [EW-1:0] sum;

    assign sum      = ptr_in + (word ? EW'(2) : EW'(1));
    assign ptr_next = ext ? sum : {{HW{1'b0}}, sum[DW-1:0]};

endmodule

// File: rtl/ptr_agu_addr.sv
module ptr_agu_addr
    import ptr_agu_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 20
) (
    input  agu_state_e    state,
    input  acc_kind_e     kind,
    input  logic          load,
    input  logic          word,
    input  logic [AW-1:0] ptr_lo,
    input  logic [DW-1:0] sp,
    output logic          mem_req,
    output logic          mem_we,
    output logic          mem_word,
    output logic [AW-1:0] mem_addr
);

    logic use_sp;

    always_comb begin
        mem_req  = (state == ST_MEM1) || (state == ST_MEM2);
        use_sp   = ((kind == KIND_PUSH) && (state == ST_MEM2)) ||
                   ((kind == KIND_POP)  && (state == ST_MEM1));
        if (is_stack(kind)) begin
            mem_we   = mem_req && (state == ST_MEM2);
            mem_word = mem_req;
        end else begin
            mem_we   = mem_req && !load;
            mem_word = mem_req && word;
        end
        if (use_sp)                mem_addr = AW'(sp);
        else if (kind == KIND_EXT) mem_addr = ptr_lo;
        else                       mem_addr = AW'(ptr_lo[DW-1:0]);
    end

endmodule

// File: rtl/ptr_agu.sv
module ptr_agu
    import ptr_agu_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_valid,
    input  logic [REG_IDX_W-1:0] cmd_field,
    input  logic [REG_IDX_W-1:0] cmd_dreg,
    input  logic                 cmd_word,
    input  logic                 cmd_load,
    input  logic [1:0]           cmd_kind,
    output logic                 busy,
    output logic [REG_IDX_W-1:0] rf_ra_addr,
    input  logic [DATA_W-1:0]    rf_ra_data,
    output logic [REG_IDX_W-1:0] rf_rb_addr,
    input  logic [DATA_W-1:0]    rf_rb_data,
    output logic                 rf_we,
    output logic [REG_IDX_W-1:0] rf_waddr,
    output logic [DATA_W-1:0]    rf_wdata,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic                 mem_word,
    output logic [MADDR_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]    mem_wdata,
    input  logic [DATA_W-1:0]    mem_rdata,
    input  logic                 mem_ack,
    output logic [DATA_W-1:0]    sp_value
);

    agu_cmd_t   cmd_in;
    agu_cmd_t   cmd_q;
    agu_state_e state;

    logic [EXT_W-1:0]     ptr_q;
    logic [EXT_W-1:0]     ptr_next;
    logic [DATA_W-1:0]    dbuf_q;
    logic [REG_IDX_W-1:0] hi_idx;
    logic                 is_ext;
    logic                 stack_op;
    logic                 data_load;
    logic                 hit_lo;
    logic                 hit_hi;
    logic                 unused_hi_byte;

    assign cmd_in = decode_cmd(cmd_field, cmd_dreg, cmd_word, cmd_load, cmd_kind);

    ptr_agu_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_in    (cmd_in),
        .mem_ack   (mem_ack),
        .state     (state),
        .cmd_q     (cmd_q)
    );

    assign busy      = (state != ST_IDLE);
    assign is_ext    = (cmd_q.kind == KIND_EXT);
    assign stack_op  = is_stack(cmd_q.kind);
    assign data_load = cmd_q.load && !stack_op;
    assign hi_idx    = cmd_q.preg + REG_IDX_W'(WORD_BYTES);
    assign hit_lo    = data_load && (cmd_q.dreg == cmd_q.preg);
    assign hit_hi    = data_load && (cmd_q.dreg == hi_idx);

    // Port A: pointer low word, except during a store access where it sources data.
    assign rf_ra_addr = (state == ST_MEM1 && !stack_op && !cmd_q.load) ? cmd_q.dreg : cmd_q.preg;
    assign rf_rb_addr = hi_idx;
    assign unused_hi_byte = ^rf_rb_data[DATA_W-1:HI_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q  <= '0;
            dbuf_q <= '0;
        end else begin
            if (state == ST_GRAB) begin
                ptr_q <= is_ext ? {rf_rb_data[HI_W-1:0], rf_ra_data}
                                : {{HI_W{1'b0}}, rf_ra_data};
            end
            if (state == ST_MEM1 && mem_ack && !mem_we) begin
                dbuf_q <= mem_rdata;
            end
        end
    end

    ptr_agu_sp #(
        .W    (DATA_W),
        .STEP (WORD_BYTES)
    ) u_sp (
        .clk (clk),
        .rst (rst),
        .dec (state == ST_GRAB && cmd_q.kind == KIND_PUSH),
        .inc (state == ST_MEM1 && mem_ack && cmd_q.kind == KIND_POP),
        .sp  (sp_value)
    );

    ptr_agu_step #(
        .DW (DATA_W),
        .EW (EXT_W)
    ) u_step (
        .ptr_in   (ptr_q),
        .ext      (is_ext),
        .word     (stack_op || cmd_q.word),
        .ptr_next (ptr_next)
    );

    ptr_agu_addr #(
        .DW (DATA_W),
        .AW (MADDR_W)
    ) u_addr (
        .state    (state),
        .kind     (cmd_q.kind),
        .load     (cmd_q.load),
        .word     (cmd_q.word),
        .ptr_lo   (ptr_q[MADDR_W-1:0]),
        .sp       (sp_value),
        .mem_req  (mem_req),
        .mem_we   (mem_we),
        .mem_word (mem_word),
        .mem_addr (mem_addr)
    );

    assign mem_wdata = stack_op ? dbuf_q : rf_ra_data;

    always_comb begin
        rf_we    = 1'b0;
        rf_waddr = cmd_q.preg;
        rf_wdata = ptr_next[DATA_W-1:0];
        unique case (state)
            ST_WB_LO: rf_we = cmd_q.autoinc && !hit_lo;
            ST_WB_HI: begin
                rf_we    = cmd_q.autoinc && !hit_hi;
                rf_waddr = hi_idx;
                rf_wdata = {{(DATA_W-HI_W){1'b0}}, ptr_next[EXT_W-1:DATA_W]};
            end
            ST_WB_DATA: begin
                rf_we    = 1'b1;
                rf_waddr = cmd_q.dreg;
                rf_wdata = cmd_q.word ? dbuf_q : {{(DATA_W-BYTE_W){1'b0}}, dbuf_q[BYTE_W-1:0]};
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ptr_agu_chk.sv
module ptr_agu_chk
    import ptr_agu_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               busy,
    input logic               mem_req,
    input logic               mem_ack,
    input logic               mem_we,
    input logic               mem_word,
    input logic [MADDR_W-1:0] mem_addr,
    input logic               rf_we,
    input logic [DATA_W-1:0]  sp_value
);

    a_r6_req_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_word)));

    a_r6_no_write_in_req: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> !mem_req);

    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_req && !rf_we));

    a_r4_sp_step: assert property (@(posedge clk) disable iff (rst)
        (sp_value != $past(sp_value)) |->
            ((sp_value == $past(sp_value) - DATA_W'(2)) || (sp_value == $past(sp_value) + DATA_W'(2))));

    a_r5_sp_only_busy: assert property (@(posedge clk) disable iff (rst)
        (sp_value != $past(sp_value)) |-> $past(busy));

endmodule

bind ptr_agu ptr_agu_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .mem_req  (mem_req),
    .mem_ack  (mem_ack),
    .mem_we   (mem_we),
    .mem_word (mem_word),
    .mem_addr (mem_addr),
    .rf_we    (rf_we),
    .sp_value (sp_value)
);

// File: tb/ptr_agu_tb_top.sv
module ptr_agu_tb_top;

    logic clk = 1'b0;
    always #5 clk = ~clk;
    logic rst = 1'b1;

    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_field = '0, cmd_dreg = '0;
    logic        cmd_word = 1'b0, cmd_load = 1'b0;
    logic [1:0]  cmd_kind = '0;
    logic        busy, rf_we, mem_req, mem_we, mem_word;
    logic [7:0]  rf_ra_addr, rf_rb_addr, rf_waddr;
    logic [15:0] rf_ra_data, rf_rb_data, rf_wdata, mem_wdata, sp_value;
    logic [15:0] mem_rdata;
    logic        mem_ack;
    logic [19:0] mem_addr;

    ptr_agu dut_i (.*);

    // register file model
    logic [15:0] rf [128];
    logic        tb_rf_we = 1'b0;
    logic [7:0]  tb_rf_idx = '0;
    logic [15:0] tb_rf_val = '0;
    assign rf_ra_data = rf[rf_ra_addr[7:1]];
    assign rf_rb_data = rf[rf_rb_addr[7:1]];
    always @(posedge clk) begin
        if (rf_we)         rf[rf_waddr[7:1]] <= rf_wdata;
        else if (tb_rf_we) rf[tb_rf_idx[7:1]] <= tb_rf_val;
    end

    // memory model and scoreboard monitor
    typedef struct { logic we; logic [19:0] addr; logic word; logic [15:0] wdata; } txn_t;
    txn_t        expq[$];
    bit [7:0]    mem [int];
    logic        tb_mem_we = 1'b0;
    logic [19:0] tb_mem_addr = '0;
    logic [7:0]  tb_mem_val = '0;
    int          lat = 0;
    logic        exp_wb = 1'b0;
    logic [7:0]  exp_wb_idx = '0;
    int checks = 0, errors = 0, m_checks = 0, m_errors = 0;
    int          cnt;
    logic [19:0] held;
    logic        hold_bad, ack_last;

    function automatic logic [7:0] rd8(input logic [19:0] a);
        return mem.exists(int'(a)) ? mem[int'(a)] : 8'h00;
    endfunction
    function automatic logic [15:0] rd16(input logic [19:0] a);
        return {rd8(a + 20'd1), rd8(a)};
    endfunction

    task automatic mchk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        m_checks++;
        if (act !== exp) begin
            m_errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst) begin
            mem_ack = 1'b0; mem_rdata = '0; cnt = 0; hold_bad = 1'b0; ack_last = 1'b0;
        end else if (tb_mem_we) begin
            mem[int'(tb_mem_addr)] = tb_mem_val;
        end else if (mem_ack) begin
            mem_ack = 1'b0; cnt = 0;
            if (ack_last) begin
                mchk("R6 R2 R7 pointer write in cycle after ack", {31'd0, rf_we}, {31'd0, exp_wb});
                if (exp_wb) mchk("R6 pointer write index", {24'd0, rf_waddr}, {24'd0, exp_wb_idx});
            end
            ack_last = 1'b0;
        end else if (mem_req) begin
            if (cnt == 0) held = mem_addr;
            else if (mem_addr !== held) hold_bad = 1'b1;
            if (cnt >= lat) begin
                if (expq.size() == 0) begin
                    m_checks++; m_errors++;
                    $display("FAIL R8: unexpected request actual addr %h expected none", mem_addr);
                end else begin
                    txn_t e;
                    e = expq.pop_front();
                    mchk("R6 address held until ack", {31'd0, hold_bad}, 32'd0);
                    mchk("R1 R3 R4 R5 access address", {12'd0, mem_addr}, {12'd0, e.addr});
                    mchk("R1 R4 R5 access direction", {31'd0, mem_we}, {31'd0, e.we});
                    mchk("R1 R4 R5 access size", {31'd0, mem_word}, {31'd0, e.word});
                    if (e.we) mchk("R1 R4 R5 write data", {16'd0, mem_wdata}, {16'd0, e.wdata});
                end
                ack_last = (expq.size() == 0);
                if (mem_we) begin
                    mem[int'(mem_addr)] = mem_wdata[7:0];
                    if (mem_word) mem[int'(mem_addr + 20'd1)] = mem_wdata[15:8];
                end else begin
                    mem_rdata = rd16(mem_addr);
                end
                mem_ack = 1'b1; hold_bad = 1'b0;
            end else begin
                cnt++;
            end
        end
    end

    // driver side
    logic [15:0] exp_rf [128];
    logic [15:0] sp_exp = '0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic set_reg(input logic [7:0] idx, input logic [15:0] v);
        @(negedge clk); tb_rf_we = 1'b1; tb_rf_idx = idx; tb_rf_val = v;
        @(negedge clk); tb_rf_we = 1'b0;
    endtask

    task automatic set_mem(input logic [19:0] a, input logic [7:0] v);
        @(posedge clk); tb_mem_we = 1'b1; tb_mem_addr = a; tb_mem_val = v;
        @(posedge clk); tb_mem_we = 1'b0;
    endtask

    task automatic run_op(input logic [7:0] field, input logic [7:0] dreg, input bit word,
                          input bit load, input logic [1:0] kind, input int latency,
                          input bit spam, input string tag);
        logic [7:0]  idx, hidx;
        logic        ai, dload;
        logic [23:0] ptr, nptr;
        logic [19:0] a;
        logic [15:0] d;
        int          step, guard;
        idx = {field[7:1], 1'b0}; hidx = idx + 8'd2; ai = field[0];
        dload = load && (kind < 2);
        for (int i = 0; i < 128; i++) exp_rf[i] = rf[i];
        ptr  = (kind == 2'd1) ? {rf[hidx[7:1]][7:0], rf[idx[7:1]]} : {8'h00, rf[idx[7:1]]};
        step = (kind >= 2'd2 || word) ? 2 : 1;
        nptr = ptr + 24'(step);
        if (kind != 2'd1) nptr[23:16] = 8'h00;
        a = (kind == 2'd1) ? ptr[19:0] : {4'h0, ptr[15:0]};
        d = 16'h0;
        case (kind)
            2'd0, 2'd1: begin
                if (load) begin
                    d = word ? rd16(a) : {8'h00, rd8(a)};
                    expq.push_back('{1'b0, a, word, 16'h0});
                end else begin
                    expq.push_back('{1'b1, a, word, rf[dreg[7:1]]});
                end
            end
            2'd2: begin
                sp_exp = sp_exp - 16'd2;
                d = rd16({4'h0, ptr[15:0]});
                expq.push_back('{1'b0, {4'h0, ptr[15:0]}, 1'b1, 16'h0});
                expq.push_back('{1'b1, {4'h0, sp_exp}, 1'b1, d});
            end
            default: begin
                d = rd16({4'h0, sp_exp});
                expq.push_back('{1'b0, {4'h0, sp_exp}, 1'b1, 16'h0});
                sp_exp = sp_exp + 16'd2;
                expq.push_back('{1'b1, {4'h0, ptr[15:0]}, 1'b1, d});
            end
        endcase
        if (ai && !(dload && dreg == idx)) exp_rf[idx[7:1]] = nptr[15:0];
        if (ai && kind == 2'd1 && !(dload && dreg == hidx)) exp_rf[hidx[7:1]] = {8'h00, nptr[23:16]};
        if (dload) exp_rf[dreg[7:1]] = d;
        exp_wb = ai && !(dload && dreg == idx);
        exp_wb_idx = idx;
        lat = latency;

        @(negedge clk);
        cmd_valid = 1'b1; cmd_field = field; cmd_dreg = dreg;
        cmd_word = word; cmd_load = load; cmd_kind = kind;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk({"R8 busy after accept ", tag}, {31'd0, busy}, 32'd1);
        if (spam) begin
            cmd_valid = 1'b1; cmd_field = 8'h11; cmd_kind = 2'd3;
            repeat (2) @(negedge clk);
            cmd_valid = 1'b0;
        end
        guard = 0;
        while (busy === 1'b1 && guard < 200) begin @(negedge clk); guard++; end
        chk({"R8 busy falls ", tag}, {31'd0, busy}, 32'd0);
        repeat (3) @(negedge clk);
        chk({"R8 no further activity ", tag}, {30'd0, busy, mem_req}, 32'd0);
        chk({"R6 all accesses seen ", tag}, expq.size(), 32'd0);
        chk({tag, " pointer low"}, {16'd0, rf[idx[7:1]]}, {16'd0, exp_rf[idx[7:1]]});
        chk({tag, " pointer high reg"}, {16'd0, rf[hidx[7:1]]}, {16'd0, exp_rf[hidx[7:1]]});
        chk({tag, " data reg"}, {16'd0, rf[dreg[7:1]]}, {16'd0, exp_rf[dreg[7:1]]});
        chk({tag, " stack pointer"}, {16'd0, sp_value}, {16'd0, sp_exp});
    endtask

    initial begin
        for (int i = 0; i < 128; i++) rf[i] = 16'(i * 16'h0101);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R9 reset busy", {31'd0, busy}, 32'd0);
        chk("R9 reset request", {31'd0, mem_req}, 32'd0);
        chk("R9 reset stack pointer", {16'd0, sp_value}, 32'd0);
        chk("R9 reset register write", {31'd0, rf_we}, 32'd0);

        set_reg(8'h10, 16'h1234);
        set_mem(20'h01234, 8'hCD); set_mem(20'h01235, 8'hAB);
        run_op(8'h10, 8'h20, 1, 1, 2'd0, 0, 0, "R1 word load no increment");
        run_op(8'h11, 8'h22, 0, 1, 2'd0, 2, 0, "R1 R2 byte load step 1");
        set_reg(8'h12, 16'hFFFF); set_reg(8'h24, 16'h5A5A);
        run_op(8'h13, 8'h24, 1, 0, 2'd0, 1, 0, "R2 R3 word store wraps 16 bits");
        chk("R1 word store bytes", {16'd0, rd8(20'h10000), rd8(20'h0FFFF)}, 32'h5A5A);
        set_reg(8'h14, 16'h0200); set_mem(20'h00201, 8'h77);
        run_op(8'h15, 8'h24, 0, 0, 2'd0, 3, 0, "R2 byte store step 1");
        chk("R1 byte store width", {16'd0, rd8(20'h00201), rd8(20'h00200)}, 32'h775A);
        set_reg(8'h30, 16'hFFFE); set_reg(8'h32, 16'hAB0F);
        set_mem(20'hFFFFE, 8'h11); set_mem(20'hFFFFF, 8'h22);
        run_op(8'h31, 8'h26, 1, 1, 2'd1, 1, 0, "R3 extended load carries to bit 20");
        set_reg(8'h34, 16'hFFFF); set_reg(8'h36, 16'h00FF);
        run_op(8'h35, 8'h24, 0, 0, 2'd1, 0, 0, "R3 extended byte store wraps 24 bits");
        chk("R3 extended store at top of 20-bit space", {24'd0, rd8(20'hFFFFF)}, 32'h5A);
        run_op(8'h11, 8'h00, 1, 0, 2'd2, 1, 0, "R4 push with increment");
        set_reg(8'h40, 16'h0300);
        run_op(8'h40, 8'h00, 1, 0, 2'd3, 2, 0, "R5 pop no increment");
        chk("R5 pop data stored", {16'd0, rd16(20'h00300)}, {16'd0, rd16(20'h01235)});
        run_op(8'h10, 8'h00, 1, 0, 2'd2, 0, 0, "R4 push no increment");
        run_op(8'h41, 8'h00, 1, 0, 2'd3, 1, 0, "R5 pop with increment");
        set_reg(8'h42, 16'h1234);
        run_op(8'h43, 8'h42, 1, 1, 2'd0, 1, 0, "R7 load wins over increment");
        run_op(8'h10, 8'h28, 1, 1, 2'd0, 3, 1, "R8 command while busy ignored");

        $display("Simulation finished: %0d checks, %0d errors", checks + m_checks, errors + m_errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks + m_checks + 1, errors + m_errors + 1);
        $finish;
    end

endmodule